// File: doc/BRIEF.md
# I2C Slave Address Listener

This block is the receive front end of an I2C target. It samples the open-drain clock and data lines into the system clock domain and waits for a start condition. After the start it collects an address frame of seven address bits and one direction bit. It then decides whether the frame is meant for this device. A frame qualifies when its address equals the programmed own address, or when the whole frame is the general-call pattern. A qualifying frame gets an acknowledge in the ninth clock.

When the ninth clock falls after an acknowledge, the block clears a pending flag and raises an interrupt. It also holds SCL low, which stretches the clock for as long as the host has not serviced the event. A one-cycle clear strobe from the host sets the flag again, drops the interrupt and lets SCL go. A stop condition on the bus returns the block to idle and releases both lines. A frame that does not qualify makes the block ignore the bus until the next start. Data bytes, controller operation and arbitration are handled elsewhere.

Top module: `i2c_addr_listener`

## Requirements
- R1: After reset both pull-low enables are 0, the pending flag is 1, the interrupt is 0, and the three status outputs are 0.
- R2: A start is SDA falling while SCL is high. The eight SCL rising edges after it sample the frame most significant bit first: frame bits 7..1 form the address and bit 0 is the direction (1 = read).
- R3: When frame bits 7..1 equal the nonzero own address, SDA is pulled low from the eighth SCL falling edge until the ninth SCL falling edge.
- R4: The frame 0x00 (address 0, direction 0) is acknowledged as a general call. The frame 0x01 is never acknowledged, and an own address of 0 matches nothing.
- R5: On the ninth SCL falling edge of an acknowledged frame, the pending flag goes to 0 and the interrupt goes to 1.
- R6: While the pending flag is 0 after an acknowledged frame, SCL is pulled low, even when the controller releases it.
- R7: A one-cycle clear strobe sets the pending flag to 1, clears the interrupt and releases SCL.
- R8: A frame that does not qualify leaves SDA released in the ninth clock and raises no interrupt. Later clocks are ignored until the next start, even when they carry a matching frame.
- R9: A stop is SDA rising while SCL is high. It returns the block to idle with both lines released. Clocks that follow without a start produce no acknowledge.
- R10: The status outputs are general-call hit, own-address hit and direction. They are loaded on the ninth falling edge of an acknowledged frame and cleared by every start.
- R11: A start that arrives during an address frame (repeated start) discards the partial frame and begins a new one.
- R12: SCL and SDA are never pulled low by the block at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen on the pin |
| sda_i | input | 1 | SDA line level as seen on the pin |
| own_addr_i | input | 7 | Programmed own 7-bit address |
| pend_clr_i | input | 1 | One-cycle strobe that sets the pending flag back to 1 |
| scl_pull_o | output | 1 | Pull SCL low when 1 (clock stretch) |
| sda_pull_o | output | 1 | Pull SDA low when 1 (acknowledge) |
| pend_o | output | 1 | Pending flag, 0 while an event awaits service |
| irq_o | output | 1 | Interrupt request, high while the pending flag is 0 |
| gen_call_o | output | 1 | Last acknowledged frame was a general call |
| own_hit_o | output | 1 | Last acknowledged frame matched the own address |
| rw_o | output | 1 | Direction bit of the last acknowledged frame |

## Verification
A wrong bit count or shift order shows at the pins within one frame. The acknowledge appears in the wrong clock or on the wrong address, so the controller samples SDA high where low was due, or the reverse. A controller state that forgets the hold makes SCL rise while the interrupt is still high, a few system cycles after the ninth falling edge. A state that never leaves the hold keeps SCL low after the clear strobe, which is visible within a handful of cycles. A wrong latch of the match result shows on the status outputs as soon as the interrupt rises.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int LSN_ADDR_W  = 7;
  localparam int LSN_FRAME_W = LSN_ADDR_W + 1;

  typedef enum logic [2:0] {
    LSN_IDLE = 3'd0,
    LSN_ADDR = 3'd1,
    LSN_ACK  = 3'd2,
    LSN_HOLD = 3'd3,
    LSN_SKIP = 3'd4
  } lsn_state_e;

  // general call: all address bits zero and a write direction
  function automatic logic frame_is_gen_call(input logic [LSN_FRAME_W-1:0] frame);
    return frame == '0;
  endfunction

  // own-address hit, address zero is reserved and never matches
  function automatic logic frame_is_own(input logic [LSN_FRAME_W-1:0] frame,
                                        input logic [LSN_ADDR_W-1:0]  own);
    return (frame[LSN_FRAME_W-1:1] == own) && (own != '0);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_shift.sv
module i2c_addr_shift #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               full_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      frame_o <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      frame_o <= '0;
    end else if (shift_i && (cnt_q != CNT_FULL)) begin
      cnt_q   <= cnt_q + 1'b1;
      frame_o <= {frame_o[FRAME_W-2:0], bit_i};
    end
  end

  assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/i2c_listen_ctrl.sv
module i2c_listen_ctrl
  import i2c_addr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic frame_full,
  input  logic hit_gc,
  input  logic hit_own,
  input  logic frame_rw,
  input  logic pend_clr_i,
  output logic shift_en,
  output logic shift_clr,
  output logic scl_pull,
  output logic sda_pull,
  output logic pend,
  output logic gen_call,
  output logic own_hit,
  output logic rw
);
  lsn_state_e state_q, state_d;
  logic       ninth_fall;

  assign ninth_fall = (state_q == LSN_ACK) && scl_fall;

  always_comb begin
    state_d = state_q;
    if (start_evt) begin
      state_d = LSN_ADDR;
    end else if (stop_evt) begin
      state_d = LSN_IDLE;
    end else begin
      case (state_q)
        LSN_ADDR: if (frame_full && scl_fall)
                    state_d = (hit_gc || hit_own) ? LSN_ACK : LSN_SKIP;
        LSN_ACK:  if (scl_fall) state_d = LSN_HOLD;
        LSN_HOLD: if (pend_clr_i) state_d = LSN_SKIP;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LSN_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b1;
    end else if (ninth_fall) begin
      pend <= 1'b0;
    end else if (pend_clr_i) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_call <= 1'b0;
      own_hit  <= 1'b0;
      rw       <= 1'b0;
    end else if (start_evt) begin
      gen_call <= 1'b0;
      own_hit  <= 1'b0;
      rw       <= 1'b0;
    end else if (ninth_fall) begin
      gen_call <= hit_gc;
      own_hit  <= hit_own;
      rw       <= frame_rw;
    end
  end

  assign shift_en  = (state_q == LSN_ADDR) && scl_rise;
  assign shift_clr = start_evt;
  assign sda_pull  = (state_q == LSN_ACK);
  assign scl_pull  = (state_q == LSN_HOLD);
endmodule

// File: rtl/i2c_addr_listener.sv
module i2c_addr_listener
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [LSN_ADDR_W-1:0] own_addr_i,
  input  logic                  pend_clr_i,
  output logic                  scl_pull_o,
  output logic                  sda_pull_o,
  output logic                  pend_o,
  output logic                  irq_o,
  output logic                  gen_call_o,
  output logic                  own_hit_o,
  output logic                  rw_o
);
  logic                   scl_s, sda_s;
  logic                   scl_rise, scl_fall;
  logic                   start_evt, stop_evt;
  logic                   shift_en, shift_clr;
  logic [LSN_FRAME_W-1:0] frame;
  logic                   frame_full;
  logic                   hit_gc, hit_own, match_any;
  logic                   unused_scl;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign unused_scl = scl_s;

  i2c_addr_shift #(.FRAME_W(LSN_FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (shift_clr),
    .shift_i (shift_en),
    .bit_i   (sda_s),
    .frame_o (frame),
    .full_o  (frame_full)
  );

  assign hit_gc    = frame_is_gen_call(frame);
  assign hit_own   = frame_is_own(frame, own_addr_i);
  assign match_any = hit_gc | hit_own;

  i2c_listen_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .frame_full (frame_full),
    .hit_gc     (hit_gc),
    .hit_own    (hit_own),
    .frame_rw   (frame[0]),
    .pend_clr_i (pend_clr_i),
    .shift_en   (shift_en),
    .shift_clr  (shift_clr),
    .scl_pull   (scl_pull_o),
    .sda_pull   (sda_pull_o),
    .pend       (pend_o),
    .gen_call   (gen_call_o),
    .own_hit    (own_hit_o),
    .rw         (rw_o)
  );

  assign irq_o = ~pend_o;
endmodule

// File: rtl/i2c_addr_listener_chk.sv
module i2c_addr_listener_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic pend_o,
  input logic pend_clr_i,
  input logic gen_call_o,
  input logic own_hit_o,
  input logic stop_evt,
  input logic scl_fall,
  input logic match_any
);
  AST_NO_DUAL_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_pull_o && sda_pull_o)); // R12
  AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(match_any)); // R3
  AST_PEND_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(scl_fall)); // R5
  AST_STRETCH_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_o |-> !pend_o); // R6
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr_i && scl_pull_o) |=> (!scl_pull_o && pend_o)); // R7
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!scl_pull_o && !sda_pull_o)); // R9
  AST_STATUS_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> (gen_call_o || own_hit_o)); // R10
endmodule

bind i2c_addr_listener i2c_addr_listener_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .pend_o     (pend_o),
  .pend_clr_i (pend_clr_i),
  .gen_call_o (gen_call_o),
  .own_hit_o  (own_hit_o),
  .stop_evt   (stop_evt),
  .scl_fall   (scl_fall),
  .match_any  (match_any)
);

// File: tb/i2c_addr_listener_test.sv
module i2c_addr_listener_test;
  localparam int H = 12;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own = 7'h5A;
  logic       clr = 1'b0;
  logic       scl_pull, sda_pull, pend, irq, gc, oh, rw;
  logic       scl_bus, sda_bus;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  assign scl_bus = m_scl & ~scl_pull;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_addr_listener uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .own_addr_i(own), .pend_clr_i(clr),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .pend_o(pend),
    .irq_o(irq), .gen_call_o(gc), .own_hit_o(oh), .rw_o(rw)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_cond();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic stop_cond();
    m_scl = 1'b0; m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic ninth(output logic ack);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(H / 2);
    ack = ~sda_bus;
    tick(H / 2);
    m_scl = 1'b0; tick(Q);
  endtask

  function automatic logic exp_gc(input logic [7:0] b);
    return b == 8'h00;
  endfunction

  function automatic logic exp_own(input logic [7:0] b, input logic [6:0] a);
    return (b[7:1] == a) && (a != 7'd0);
  endfunction

  task automatic run_frame(input logic [7:0] b);
    logic ack, g, o, m;
    g = exp_gc(b);
    o = exp_own(b, own);
    m = g | o;
    start_cond();
    chk(gc == 0 && oh == 0 && rw == 0, "R10 cleared at start", {gc, oh, rw}, 0);
    send_bits(b, 8);
    ninth(ack);
    chk(ack == m, g ? "R4 general call ack" : (o ? "R3 own ack" : "R8 no ack"), ack, m);
    if (m) begin
      chk(irq == 1 && pend == 0, "R5 irq and pending at ninth fall", {irq, pend}, 2'b10);
      chk(gc == g && oh == o && rw == b[0], "R10 status", {gc, oh, rw}, {g, o, b[0]});
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(H);
      chk(scl_bus == 0, "R6 clock stretched", scl_bus, 0);
      clr = 1'b1; tick(1); clr = 1'b0; tick(4);
      chk(scl_bus == 1 && irq == 0 && pend == 1, "R7 clear releases", {scl_bus, irq, pend}, 3'b101);
      tick(H);
      m_sda = 1'b1; tick(H);
    end else begin
      chk(irq == 0 && scl_pull == 0, "R8 no irq on miss", {irq, scl_pull}, 0);
      stop_cond();
    end
    chk(scl_pull == 0 && sda_pull == 0, "R9 lines free after stop", {scl_pull, sda_pull}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic ack;
    tick(3);
    chk(scl_pull == 0 && sda_pull == 0 && pend == 1 && irq == 0 && {gc, oh, rw} == 0,
        "R1 reset state", {scl_pull, sda_pull, pend, irq, gc, oh, rw}, 7'b0010000);
    rst_n = 1'b1; tick(3);

    // R2 R3 R4 R8: full sweep of every frame against one own address
    own = 7'h5A;
    for (int b = 0; b < 256; b++) run_frame(8'(b));
    // R4: own address zero must match nothing but the general call
    own = 7'h00;
    run_frame(8'h00); run_frame(8'h01); run_frame(8'h02);
    own = 7'h7F;
    for (int b = 240; b < 256; b++) run_frame(8'(b));

    // R8: after a miss, a matching frame without start is ignored
    own = 7'h33;
    start_cond(); send_bits(8'h10, 8); ninth(ack);
    send_bits({7'h33, 1'b0}, 8); ninth(ack);
    chk(ack == 0 && irq == 0, "R8 ignored until next start", {ack, irq}, 0);
    stop_cond();

    // R9: stop in mid-frame, following clocks without start are ignored
    start_cond(); send_bits({7'h33, 1'b1}, 3); stop_cond();
    m_scl = 1'b0; tick(Q);
    send_bits({7'h33, 1'b1}, 8); ninth(ack);
    chk(ack == 0 && irq == 0, "R9 idle after stop", {ack, irq}, 0);
    stop_cond();

    // R11: repeated start discards the partial frame
    start_cond(); send_bits(8'hFF, 5);
    start_cond(); send_bits({7'h33, 1'b1}, 8); ninth(ack);
    chk(ack == 1 && irq == 1, "R11 repeated start restarts frame", {ack, irq}, 2'b11);
    chk(oh == 1 && gc == 0 && rw == 1, "R11 R10 status after restart", {gc, oh, rw}, 3'b011);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(2 * H);
    chk(scl_bus == 0 && pend == 0, "R6 long stretch", {scl_bus, pend}, 0);
    clr = 1'b1; tick(1); clr = 1'b0; tick(4);
    chk(scl_bus == 1 && irq == 0, "R7 release after long stretch", {scl_bus, irq}, 2'b10);
    m_sda = 1'b1; tick(H);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule